// File: doc/BRIEF.md
# Triggered Interval Sequence Output

This block produces one digital output waveform made of a short list of high and low intervals. The list can hold unequal lengths, and the waveform starts from a rising edge on an asynchronous trigger input. While the block is idle, a host fills a small register set through a one-cycle write port. The register set holds a start delay, a latency compensation count, a sequence length and up to eight interval lengths. All values are counts of the block's own clock, which is the fast timebase. Every output transition therefore lands on a timebase edge.

When the arm input is high, the block waits for a trigger edge and counts out the delay. It then drives the output high for the first interval and inverts the output at the end of each later interval. When the last interval ends, the output is low and a one-cycle done pulse appears. If arm is still high at that point, the block waits again and replays the same pattern on the next trigger edge. Several instances can share one trigger line to produce independent patterns.

Top module: `tseq_player`

## Requirements
- R1: A synchronous reset, active high, puts the block in its idle state with pat_out low, done low and wr_err low. It also resets delay and compensation to 0, length to 1 and every interval length to 0.
- R2: The low half of the write address space holds the control registers: address 0 is the start delay, 1 is the compensation count and 2 is the sequence length. Address 8+i holds interval length i, for i from 0 to 7. A length write of 0 is stored as 1, and a length write above 8 is stored as 8.
- R3: A trigger edge is acted on only while the block is armed. While arm is low and the block is idle, trigger activity leaves pat_out low.
- R4: Let trig_in be sampled high at clock edge k after being low, while the block is armed, and let D be the start delay. Then pat_out goes high at edge k+3+D.
- R5: After it rises, pat_out inverts at the end of each interval. Interval i (i ≥ 1) lasts exactly its programmed number of cycles, and a programmed 0 counts as 1.
- R6: The first interval lasts its programmed length minus the compensation count. If the compensation count is equal to or larger than the programmed length, the first interval lasts 1 cycle.
- R7: When the interval whose index is length−1 ends, pat_out is low. At that same edge done goes high for exactly one cycle, and pat_out stays low afterwards.
- R8: After done, the block returns to the armed state if arm is high, and the next trigger edge replays the same sequence. If arm is low, the block returns to idle.
- R9: A write that arrives while the block is not idle leaves every register unchanged and sets wr_err. An accepted write clears wr_err. The timing registers never change while the block is not idle.
- R10: Only a low-to-high transition of the trigger starts a sequence. A trigger held high across the end of a sequence does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| arm | input | 1 | Level: allow and keep re-arming for trigger edges |
| trig_in | input | 1 | Asynchronous trigger |
| pat_out | output | 1 | Pattern output |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| wr_err | output | 1 | Set by a write rejected because the block is busy |

## Verification
The bench predicts the edge of every output transition from the trigger edge, the delay and the interval table, and a scoreboard compares each predicted edge to the observed one. A design that is off by one cycle in the synchronizer or in a counter reload moves an edge and is reported. The corner cases tested are an odd and an even length, a compensation count larger than the first interval, a zero interval, and the length clamp at 0 and at 12. A design that got any of these wrong would produce the wrong number of edges or a final level left high. Further stimulus covers writes while armed, which must not change the replayed pattern, and triggers while disarmed, which must produce nothing. One trigger is held high through the done pulse; a level-sensitive start would replay the pattern there.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_DELAY = 3'd2,
      ST_RUN   = 3'd3,
      ST_DONE  = 3'd4
   } tseq_state_e;

   localparam int unsigned REG_DELAY = 0;
   localparam int unsigned REG_COMP  = 1;
   localparam int unsigned REG_LEN   = 2;
endpackage

// File: rtl/tseq_edge.sv
module tseq_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tseq_regs.sv
module tseq_regs #(
   parameter int unsigned MAX_IV = 8,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned LEN_W  = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [CNT_W-1:0]               wr_data,
   input  logic                           accept,
   output logic [CNT_W-1:0]               delay_cnt,
   output logic [CNT_W-1:0]               comp_cnt,
   output logic [LEN_W-1:0]               seq_len,
   output logic [MAX_IV-1:0][CNT_W-1:0]   durs,
   output logic                           wr_err
);
   import tseq_pkg::*;
   localparam int unsigned IDX_W = ADDR_W - 1;

   logic take;
   logic in_table;
   assign take     = wr_en & accept;
   assign in_table = wr_addr[ADDR_W-1];

   for (genvar g = 0; g < MAX_IV; g++) begin : g_dur
      always_ff @(posedge clk) begin
         if (rst)
            durs[g] <= '0;
         else if (take && in_table && wr_addr[IDX_W-1:0] == IDX_W'(g))
            durs[g] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         delay_cnt <= '0;
         comp_cnt  <= '0;
         seq_len   <= LEN_W'(1);
      end else if (take && !in_table) begin
         if (wr_addr[IDX_W-1:0] == IDX_W'(REG_DELAY))
            delay_cnt <= wr_data;
         if (wr_addr[IDX_W-1:0] == IDX_W'(REG_COMP))
            comp_cnt <= wr_data;
         if (wr_addr[IDX_W-1:0] == IDX_W'(REG_LEN)) begin
            if (wr_data == '0)
               seq_len <= LEN_W'(1);
            else if (wr_data > CNT_W'(MAX_IV))
               seq_len <= LEN_W'(MAX_IV);
            else
               seq_len <= wr_data[LEN_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        wr_err <= 1'b0;
      else if (wr_en) wr_err <= ~accept;
   end
endmodule

// File: rtl/tseq_sequencer.sv
module tseq_sequencer #(
   parameter int unsigned MAX_IV  = 8,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned LEN_W   = 4,
   parameter int unsigned IDX_W   = 3,
   parameter bit          COMP_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         arm,
   input  logic                         rise,
   input  logic [CNT_W-1:0]             delay_cnt,
   input  logic [CNT_W-1:0]             comp_cnt,
   input  logic [LEN_W-1:0]             seq_len,
   input  logic [MAX_IV-1:0][CNT_W-1:0] durs,
   output logic                         pat,
   output logic                         done,
   output logic                         idle
);
   import tseq_pkg::*;

   tseq_state_e        state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic               pat_q;

   logic [CNT_W-1:0]   first_len;
   logic [CNT_W-1:0]   first_load;
   logic [IDX_W-1:0]   idx_nx;
   logic [CNT_W-1:0]   next_dur;
   logic [CNT_W-1:0]   next_load;
   logic               is_last;

   if (COMP_EN) begin : g_comp
      assign first_len = (durs[0] > comp_cnt) ? durs[0] - comp_cnt : CNT_W'(1);
   end else begin : g_nocomp
      assign first_len = (durs[0] == '0) ? CNT_W'(1) : durs[0];
   end

   assign first_load = first_len - CNT_W'(1);
   assign idx_nx     = idx_q + IDX_W'(1);
   assign next_dur   = durs[idx_nx];
   assign next_load  = (next_dur == '0) ? '0 : next_dur - CNT_W'(1);
   assign is_last    = (LEN_W'(idx_q) + LEN_W'(1)) == seq_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         pat_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (arm) state_q <= ST_ARMED;
            end
            ST_ARMED: begin
               if (rise) begin
                  state_q <= ST_DELAY;
                  cnt_q   <= delay_cnt;
               end else if (!arm) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_DELAY: begin
               if (cnt_q == '0) begin
                  state_q <= ST_RUN;
                  pat_q   <= 1'b1;
                  idx_q   <= '0;
                  cnt_q   <= first_load;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_RUN: begin
               if (cnt_q == '0) begin
                  if (is_last) begin
                     state_q <= ST_DONE;
                     pat_q   <= 1'b0;
                  end else begin
                     pat_q <= ~pat_q;
                     idx_q <= idx_nx;
                     cnt_q <= next_load;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_DONE: begin
               state_q <= arm ? ST_ARMED : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign pat  = pat_q;
   assign done = (state_q == ST_DONE);
   assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/tseq_player.sv
module tseq_player #(
   parameter int unsigned MAX_INTERVALS = 8,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          COMP_EN       = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [$clog2(MAX_INTERVALS):0]    wr_addr,
   input  logic [CNT_W-1:0]                  wr_data,
   input  logic                              arm,
   input  logic                              trig_in,
   output logic                              pat_out,
   output logic                              done,
   output logic                              wr_err
);
   localparam int unsigned IDX_W  = $clog2(MAX_INTERVALS);
   localparam int unsigned ADDR_W = IDX_W + 1;
   localparam int unsigned LEN_W  = $clog2(MAX_INTERVALS + 1);

   if (MAX_INTERVALS < 4 || (MAX_INTERVALS & (MAX_INTERVALS - 1)) != 0) begin : g_bad_iv
      $error("MAX_INTERVALS must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < LEN_W + 1) begin : g_bad_cnt
      $error("CNT_W too narrow for the length register");
   end

   logic                                 trig_rise;
   logic                                 seq_idle;
   logic [CNT_W-1:0]                     cfg_delay;
   logic [CNT_W-1:0]                     cfg_comp;
   logic [LEN_W-1:0]                     cfg_len;
   logic [MAX_INTERVALS-1:0][CNT_W-1:0]  cfg_durs;

   tseq_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .async_in (trig_in),
      .rise     (trig_rise)
   );

   tseq_regs #(
      .MAX_IV (MAX_INTERVALS),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .accept    (seq_idle),
      .delay_cnt (cfg_delay),
      .comp_cnt  (cfg_comp),
      .seq_len   (cfg_len),
      .durs      (cfg_durs),
      .wr_err    (wr_err)
   );

   tseq_sequencer #(
      .MAX_IV  (MAX_INTERVALS),
      .CNT_W   (CNT_W),
      .LEN_W   (LEN_W),
      .IDX_W   (IDX_W),
      .COMP_EN (COMP_EN)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .arm       (arm),
      .rise      (trig_rise),
      .delay_cnt (cfg_delay),
      .comp_cnt  (cfg_comp),
      .seq_len   (cfg_len),
      .durs      (cfg_durs),
      .pat       (pat_out),
      .done      (done),
      .idle      (seq_idle)
   );
endmodule

// File: rtl/tseq_player_chk.sv
module tseq_player_chk #(
   parameter int unsigned CFG_W = 320
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic             pat_out,
   input logic             done,
   input logic             wr_err,
   input logic             idle,
   input logic [CFG_W-1:0] cfg
);
   logic rst_q;

   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         p_reset_quiet_r1: assert (!pat_out && !done && !wr_err)
            else $error("outputs not quiet after reset");
      end
      rst_q <= rst;
   end

   p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
      idle |-> !pat_out);

   p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_level_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> !pat_out);

   p_reject_flag_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !idle) |=> wr_err);

   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      !idle |=> $stable(cfg));
endmodule

bind tseq_player tseq_player_chk #(
   .CFG_W ((MAX_INTERVALS + 2) * CNT_W)
) u_tseq_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .pat_out (pat_out),
   .done    (done),
   .wr_err  (wr_err),
   .idle    (seq_idle),
   .cfg     ({cfg_delay, cfg_comp, cfg_durs})
);

// File: tb/tseq_player_bench.sv
module tseq_player_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        arm = 1'b0;
   logic        trig = 1'b0;
   logic        pat_out, done, wr_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   tseq_player u_tseq_player (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .arm(arm), .trig_in(trig), .pat_out(pat_out), .done(done), .wr_err(wr_err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      bit    is_done;
      bit    lvl;
      string req;
   } ev_t;
   ev_t q[$];

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int unsigned m_delay = 0, m_comp = 0, m_len = 1;
   int unsigned m_dur[8] = '{default: 0};

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Monitor: pops the queue as events appear
   bit   mon_en = 1'b0;
   logic last_pat = 1'b0;
   logic last_done = 1'b0;

   task automatic take(bit isd, bit lvl);
      ev_t e;
      if (q.size() == 0) begin
         check(1'b0, isd ? "R7" : "R5", "unexpected event at cycle", cyc, -1);
      end else begin
         e = q.pop_front();
         check(e.is_done == isd && e.lvl == lvl, e.req, "event kind/level",
               {isd, lvl}, {e.is_done, e.lvl});
         check(e.at == cyc, e.req, "event cycle", cyc, e.at);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (pat_out !== last_pat) begin
            take(1'b0, pat_out);
            last_pat = pat_out;
         end
         if (done && !last_done) take(1'b1, 1'b1);
         last_done = done;
      end
   end

   task automatic push(int at, bit isd, bit lvl, string req);
      ev_t e;
      e.at = at; e.is_done = isd; e.lvl = lvl; e.req = req;
      q.push_back(e);
   endtask

   task automatic reg_write(int addr, int unsigned data, bit expect_ok);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      check(wr_err == !expect_ok, "R9", "wr_err after write", wr_err, !expect_ok);
      if (expect_ok) begin
         if (addr == 0) m_delay = data;
         else if (addr == 1) m_comp = data;
         else if (addr == 2) m_len = (data == 0) ? 1 : (data > 8 ? 8 : data);
         else if (addr >= 8) m_dur[addr-8] = data;
      end
   endtask

   // Driver: raises trigger and pushes the predicted events
   task automatic fire(bit expect_run, int hold, string first_req);
      int k, t, d;
      bit lvl;
      @(negedge clk);
      trig = 1'b1;
      k = cyc + 1;
      if (expect_run) begin
         t = k + 3 + int'(m_delay);
         push(t, 1'b0, 1'b1, first_req);
         lvl = 1'b1;
         for (int i = 0; i < int'(m_len); i++) begin
            if (i == 0) d = (m_dur[0] > m_comp) ? int'(m_dur[0] - m_comp) : 1;
            else        d = (m_dur[i] == 0) ? 1 : int'(m_dur[i]);
            t += d;
            if (i == int'(m_len) - 1) begin
               if (lvl) push(t, 1'b0, 1'b0, "R7");
               push(t, 1'b1, 1'b1, "R7");
            end else begin
               lvl = ~lvl;
               push(t, 1'b0, lvl, (i == 0) ? "R6" : "R5");
            end
         end
      end
      repeat (hold) @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic drain(string req);
      int n = 0;
      while (q.size() > 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      check(q.size() == 0, req, "events still pending", q.size(), 0);
      check(pat_out == 1'b0, req, "pat_out rests low", pat_out, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(pat_out == 1'b0, "R1", "pat_out after reset", pat_out, 0);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      check(wr_err == 1'b0, "R1", "wr_err after reset", wr_err, 0);
      mon_en = 1'b1;

      // R2 R4 R5: even length pattern, with a zero interval
      reg_write(0, 4, 1'b1);
      reg_write(2, 4, 1'b1);
      reg_write(8, 5, 1'b1);
      reg_write(9, 3, 1'b1);
      reg_write(10, 0, 1'b1);
      reg_write(11, 6, 1'b1);
      arm = 1'b1;
      repeat (2) @(negedge clk);
      fire(1'b1, 2, "R4");
      drain("R5");

      // R9: write while armed is rejected, R8: replay with same values
      reg_write(0, 9, 1'b0);
      reg_write(8, 40, 1'b0);
      fire(1'b1, 3, "R8");
      drain("R8");

      // R3: disarm, triggers ignored
      arm = 1'b0;
      repeat (3) @(negedge clk);
      reg_write(0, 0, 1'b1);   // accepted, clears wr_err (R9)
      fire(1'b0, 3, "R3");
      repeat (20) @(negedge clk);
      check(q.size() == 0 && pat_out == 1'b0, "R3", "trigger while disarmed", pat_out, 0);

      // R6: compensation, odd length, zero delay
      reg_write(1, 3, 1'b1);
      reg_write(2, 3, 1'b1);
      reg_write(8, 6, 1'b1);
      reg_write(9, 4, 1'b1);
      reg_write(10, 5, 1'b1);
      arm = 1'b1;
      repeat (2) @(negedge clk);
      fire(1'b1, 2, "R4");
      drain("R6");

      // R6: compensation larger than first interval
      arm = 1'b0;
      repeat (3) @(negedge clk);
      reg_write(1, 10, 1'b1);
      reg_write(0, 2, 1'b1);
      arm = 1'b1;
      repeat (2) @(negedge clk);
      fire(1'b1, 2, "R4");
      drain("R6");

      // R2: length clamp at 0 -> 1
      arm = 1'b0;
      repeat (3) @(negedge clk);
      reg_write(1, 0, 1'b1);
      reg_write(2, 0, 1'b1);
      arm = 1'b1;
      repeat (2) @(negedge clk);
      fire(1'b1, 2, "R4");
      drain("R2");

      // R2: length clamp at 12 -> 8, all table slots used
      arm = 1'b0;
      repeat (3) @(negedge clk);
      reg_write(2, 12, 1'b1);
      for (int i = 0; i < 8; i++) reg_write(8 + i, 2 + 3 * i, 1'b1);
      arm = 1'b1;
      repeat (2) @(negedge clk);
      fire(1'b1, 2, "R4");
      drain("R2");

      // R10: trigger held high through the end, no second run
      fire(1'b1, 150, "R4");
      drain("R10");
      check(done == 1'b0, "R10", "no restart on held trigger", done, 0);
      fire(1'b1, 2, "R10");
      drain("R10");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule